// File: doc/BRIEF.md
# Pseudo-Static RAM Access Controller

This block turns single-word requests from a synchronous host into correctly timed cycles on an external asynchronous 256K x 8 pseudo-static RAM. The memory has two chip enables of opposite polarity, an active-low output enable and an active-low write enable. The host offers an 18-bit word address, a byte of write data and a direction flag while `ready` is high. After the access it receives a one-clock `ack`. For a read, the returned byte appears on `rdata` at the same time.

All memory timing is set in picoseconds through parameters. The block converts each interval into whole clock periods, rounding up. An access begins with a setup clock in which the address (and, for a write, the data) is presented while the memory is deselected. Then both enables assert for the access phase. A read keeps the output enable low throughout and samples the bus on the final edge. A write keeps the write enable low and ends the internal write by dropping the enables while the write enable and the data are still held. A deselect gap then follows. After a read this gap is long enough for the memory's outputs to float before the controller may drive the bus again.

The data bus is split into a driven value, an output-enable and a returned value, so that the pad cell that combines them stays outside the block.

Top module: `psram_ctrl`

## Requirements
- R1: While `rst` is high, both enables are inactive (`mem_ce1_n`=1, `mem_ce2`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `ack`=0 and `ready`=1.
- R2: The memory is selected only as a pair: `mem_ce1_n` is low in exactly the clocks in which `mem_ce2` is high.
- R3: In a read, the address is on `mem_addr` for at least one clock before the enables assert. While the enables are active, `mem_oe_n` is low, `mem_we_n` is high and `mem_dq_oe` is 0.
- R4: The byte on `mem_dq_i` at the clock edge that ends the read access phase is returned on `rdata`.
- R5: `mem_we_n` is low only while `mem_oe_n` is high and `mem_dq_oe` is 1. The write data is driven from the setup clock onward, and the addressed memory word holds that byte afterwards.
- R6: A write ends on the enables. The enables go inactive one clock before `mem_we_n` rises, and `mem_dq_oe` is still 1 in that clock.
- R7: `ack` is high for exactly one clock, in the first clock after the access phase ends. The enables are already inactive in that clock.
- R8: After a read, neither the enables nor `mem_dq_oe` assert again for at least ceil(T_HZ_PS/CLK_PS) clocks. With the default parameters this is 7 clocks.
- R9: A request presented while `ready` is low is ignored. It starts no memory cycle and changes no memory content.
- R10: `mem_addr` does not change while the enables are active.
- R11: The enables stay active for ceil(T_RC_PS/CLK_PS) clocks in a read and ceil(T_WC_PS/CLK_PS) clocks in a write. With the defaults, both are 14 clocks at a 4000 ps clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, accepted when `ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle and able to accept a request |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte read, valid while `ack` follows a read |
| mem_addr | output | 18 | Memory address pins |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | 8 | Value driven onto the data pins |
| mem_dq_oe | output | 1 | 1 = controller drives the data pins |
| mem_dq_i | input | 8 | Value sampled from the data pins |

## Verification
The tests write bytes to the lowest and highest addresses and to the alternating-bit addresses 0x15555 and 0x2AAAA. The data patterns are complementary, so a swapped address line or data bit shows up on read-back. A read of a never-written word returns the memory model's default, which shows that `rdata` is freshly captured and not held over from an earlier access. Rewriting a word and then reading it separates a real write from stale memory contents. A read followed at once by a write measures the turnaround gap. A write request pushed in while the controller is busy must leave no trace in the memory or in the count of enable pulses.

// File: rtl/psram_pkg.sv
package psram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_RD_ACC,
      ST_WR_PULSE,
      ST_WR_END,
      ST_GAP
   } psram_state_e;

   // interval in ps -> whole clocks, rounded up, never below floor_clks
   function automatic int unsigned clks_for(input int unsigned t_ps,
                                            input int unsigned clk_ps,
                                            input int unsigned floor_clks);
      int unsigned n;
      n = (t_ps + clk_ps - 1) / clk_ps;
      return (n < floor_clks) ? floor_clks : n;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign last = (cnt == '0);

endmodule

// File: rtl/psram_pin_decode.sv
module psram_pin_decode
   import psram_pkg::*;
#(
   parameter int unsigned END_ON_ENABLE = 1
) (
   input  psram_state_e state,
   input  logic         is_wr,
   output logic         sel,
   output logic         oe_act,
   output logic         we_act,
   output logic         drive
);

   generate
      if (END_ON_ENABLE != 0) begin : g_end_on_enable
         // enables drop first, write enable is still low in the end clock
         assign sel    = (state == ST_RD_ACC) || (state == ST_WR_PULSE);
         assign we_act = (state == ST_WR_PULSE) || (state == ST_WR_END);
      end else begin : g_end_on_we
         // write enable rises first, enables are still active in the end clock
         assign sel    = (state == ST_RD_ACC) || (state == ST_WR_PULSE) ||
                         (state == ST_WR_END);
         assign we_act = (state == ST_WR_PULSE);
      end
   endgenerate

   assign oe_act = (state == ST_RD_ACC);
   assign drive  = ((state == ST_SETUP) && is_wr) ||
                   (state == ST_WR_PULSE) || (state == ST_WR_END);

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
   import psram_pkg::*;
#(
   parameter int unsigned ADDR_W          = 18,
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned CLK_PS          = 4000,
   parameter int unsigned T_RC_PS         = 55000,
   parameter int unsigned T_WC_PS         = 55000,
   parameter int unsigned T_HZ_PS         = 25000,
   parameter int unsigned T_DS_PS         = 25000,
   parameter int unsigned ADDR_SETUP_CLKS = 1,
   parameter int unsigned MIN_DESEL_CLKS  = 1,
   parameter int unsigned END_ON_ENABLE   = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output logic              ack,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce1_n,
   output logic              mem_ce2,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int unsigned RD_CLKS   = clks_for(T_RC_PS, CLK_PS, 1);
   localparam int unsigned WR_CLKS   = clks_for(T_WC_PS, CLK_PS, 1);
   localparam int unsigned GAP_RD    = umax(clks_for(T_HZ_PS, CLK_PS, 1), MIN_DESEL_CLKS);
   localparam int unsigned GAP_WR    = umax(MIN_DESEL_CLKS, 1);
   localparam int unsigned MAX_CLKS  = umax(umax(RD_CLKS, WR_CLKS),
                                            umax(umax(GAP_RD, GAP_WR), ADDR_SETUP_CLKS));
   localparam int unsigned CNT_W     = (MAX_CLKS > 1) ? $clog2(MAX_CLKS) : 1;

   localparam logic [CNT_W-1:0] LV_SETUP = CNT_W'(ADDR_SETUP_CLKS - 1);
   localparam logic [CNT_W-1:0] LV_RD    = CNT_W'(RD_CLKS - 1);
   localparam logic [CNT_W-1:0] LV_WR    = CNT_W'(WR_CLKS - 1);
   localparam logic [CNT_W-1:0] LV_GRD   = CNT_W'(GAP_RD - 1);
   localparam logic [CNT_W-1:0] LV_GWR   = CNT_W'(GAP_WR - 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("psram_ctrl: address and data widths must be at least 1");
      end
      if (CLK_PS == 0) begin : g_bad_clk
         $error("psram_ctrl: CLK_PS must be non-zero");
      end
      if (ADDR_SETUP_CLKS < 1) begin : g_bad_setup
         $error("psram_ctrl: ADDR_SETUP_CLKS must be at least 1");
      end
      if (WR_CLKS * CLK_PS < T_DS_PS) begin : g_bad_ds
         $error("psram_ctrl: write phase shorter than data setup time");
      end
   endgenerate

   psram_state_e      state, state_nxt;
   logic              is_wr;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              tmr_load, tmr_last;
   logic [CNT_W-1:0]  tmr_val;
   logic              accept, capture, ack_set;
   logic              sel, oe_act, we_act, drive;

   psram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   always_comb begin
      state_nxt = state;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      accept    = 1'b0;
      capture   = 1'b0;
      ack_set   = 1'b0;
      case (state)
         ST_IDLE: begin
            if (req_valid) begin
               state_nxt = ST_SETUP;
               tmr_load  = 1'b1;
               tmr_val   = LV_SETUP;
               accept    = 1'b1;
            end
         end
         ST_SETUP: begin
            if (tmr_last) begin
               state_nxt = is_wr ? ST_WR_PULSE : ST_RD_ACC;
               tmr_load  = 1'b1;
               tmr_val   = is_wr ? LV_WR : LV_RD;
            end
         end
         ST_RD_ACC: begin
            if (tmr_last) begin
               state_nxt = ST_GAP;
               tmr_load  = 1'b1;
               tmr_val   = LV_GRD;
               capture   = 1'b1;
               ack_set   = 1'b1;
            end
         end
         ST_WR_PULSE: begin
            if (tmr_last) begin
               state_nxt = ST_WR_END;
               tmr_load  = 1'b1;
               tmr_val   = '0;
            end
         end
         ST_WR_END: begin
            state_nxt = ST_GAP;
            tmr_load  = 1'b1;
            tmr_val   = LV_GWR;
            ack_set   = 1'b1;
         end
         ST_GAP: begin
            if (tmr_last)
               state_nxt = ST_IDLE;
         end
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         is_wr   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata   <= '0;
         ack     <= 1'b0;
      end else begin
         state <= state_nxt;
         ack   <= ack_set;
         if (accept) begin
            is_wr   <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (capture)
            rdata <= mem_dq_i;
      end
   end

   psram_pin_decode #(.END_ON_ENABLE(END_ON_ENABLE)) u_pins (
      .state  (state),
      .is_wr  (is_wr),
      .sel    (sel),
      .oe_act (oe_act),
      .we_act (we_act),
      .drive  (drive)
   );

   assign ready     = (state == ST_IDLE);
   assign mem_addr  = addr_q;
   assign mem_ce1_n = ~sel;
   assign mem_ce2   = sel;
   assign mem_oe_n  = ~oe_act;
   assign mem_we_n  = ~we_act;
   assign mem_dq_o  = wdata_q;
   assign mem_dq_oe = drive;

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
   parameter int unsigned ADDR_W        = 18,
   parameter int unsigned END_ON_ENABLE = 1
) (
   input logic              clk,
   input logic              rst,
   input logic              ready,
   input logic              ack,
   input logic [ADDR_W-1:0] addr,
   input logic              ce1_n,
   input logic              ce2,
   input logic              oe_n,
   input logic              we_n,
   input logic              dq_oe
);

   logic sel;
   assign sel = !ce1_n && ce2;

   AST_RD_SELECTED: assert property (@(posedge clk) disable iff (rst)
      !oe_n |-> sel);  // R3
   AST_RD_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
      !oe_n |-> !dq_oe);  // R3
   AST_WR_OE_OFF: assert property (@(posedge clk) disable iff (rst)
      !we_n |-> oe_n);  // R5
   AST_WR_BUS_DRIVEN: assert property (@(posedge clk) disable iff (rst)
      !we_n |-> dq_oe);  // R5
   AST_WR_END_ON_CE: assert property (@(posedge clk) disable iff (rst)
      (END_ON_ENABLE != 0 && !sel && $past(sel) && !$past(we_n)) |-> (!we_n && dq_oe));  // R6
   AST_ACK_ONE: assert property (@(posedge clk) disable iff (rst)
      ack |=> !ack);  // R7
   AST_ACK_DESELECTED: assert property (@(posedge clk) disable iff (rst)
      ack |-> !sel);  // R7
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
      (sel || dq_oe) |-> !ready);  // R9
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
      (sel && $past(sel)) |-> $stable(addr));  // R10

endmodule

bind psram_ctrl psram_ctrl_chk #(
   .ADDR_W        (ADDR_W),
   .END_ON_ENABLE (END_ON_ENABLE)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .ready (ready),
   .ack   (ack),
   .addr  (mem_addr),
   .ce1_n (mem_ce1_n),
   .ce2   (mem_ce2),
   .oe_n  (mem_oe_n),
   .we_n  (mem_we_n),
   .dq_oe (mem_dq_oe)
);

// File: tb/test_psram_ctrl.sv
`timescale 1ns/1ps
module test_psram_ctrl;

   localparam int RD_LEN = 14;  // ceil(55000/4000)
   localparam int WR_LEN = 14;
   localparam int GAP    = 7;   // ceil(25000/4000)

   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid, req_write;
   logic [17:0] req_addr;
   logic [7:0]  req_wdata;
   logic        ready, ack;
   logic [7:0]  rdata;
   logic [17:0] mem_addr;
   logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  mem_dq_o;
   logic [7:0]  mem_dq_i = 8'h00;

   always #2 clk = ~clk;

   psram_ctrl i_psram_ctrl (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .ack(ack),
      .rdata(rdata), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   typedef struct { bit rd; logic [17:0] a; logic [7:0] d; } item_t;
   item_t       sb[$];
   logic [7:0]  mem    [logic [17:0]];
   logic [7:0]  shadow [logic [17:0]];
   int          errors = 0, checks = 0, issued = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // memory model
   wire sel = !mem_ce1_n && mem_ce2;
   always @(negedge clk) begin
      if (sel && !mem_we_n) mem[mem_addr] = mem_dq_o;
      if (sel && !mem_oe_n && mem_we_n)
         mem_dq_i <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
      else
         mem_dq_i <= 8'h00;
   end

   // monitor
   logic        sel_q = 0, we_q = 1, oe_q = 0, ack_q = 0, cur_rd = 0, last_rd = 0;
   logic        addr_moved = 0, rd_bad = 0, wr_bad = 0;
   logic [17:0] addr_q = '0;
   int          cyc = 0, sel_len = 0, rd_end = 0, sel_rises = 0, pair_bad = 0;

   always @(negedge clk) begin
      if (!rst) begin
         cyc++;
         if ((mem_ce1_n == 1'b0) != (mem_ce2 == 1'b1)) pair_bad++;
         if (sel && !sel_q) begin
            sel_rises++;
            chk(mem_addr == addr_q, "R3", "address set up before enables", mem_addr, addr_q);
            if (last_rd)
               chk(cyc - rd_end >= GAP, "R8", "reselect gap after read", cyc - rd_end, GAP);
            sel_len = 1; addr_moved = 0; rd_bad = 0; cur_rd = !mem_oe_n;
         end else if (sel) begin
            sel_len++;
            if (mem_addr != addr_q) addr_moved = 1;
         end
         if (sel && cur_rd && (mem_oe_n || !mem_we_n || mem_dq_oe)) rd_bad = 1;
         if (mem_dq_oe && !oe_q && last_rd)
            chk(cyc - rd_end >= GAP, "R8", "bus drive gap after read", cyc - rd_end, GAP);
         if (!sel && sel_q) begin
            chk(sel_len == (cur_rd ? RD_LEN : WR_LEN), "R11", "enable pulse length",
                sel_len, cur_rd ? RD_LEN : WR_LEN);
            chk(!addr_moved, "R10", "address moved while selected", addr_moved, 0);
            if (cur_rd) begin
               chk(!rd_bad, "R3", "read pin levels", rd_bad, 0);
               rd_end = cyc;
            end
            last_rd = cur_rd;
         end
         if (!mem_we_n && (!mem_dq_oe || !mem_oe_n)) wr_bad = 1;
         if (mem_we_n && !we_q) begin
            chk(!sel_q, "R6", "enables off before write enable rises", sel_q, 0);
            chk(!wr_bad, "R5", "bus driven, output enable high during write", wr_bad, 0);
            wr_bad = 0;
         end
         if (ack_q) chk(!ack, "R7", "ack longer than one clock", ack, 0);
         if (ack) begin
            chk(!sel, "R7", "enables off at ack", sel, 0);
            if (sb.size() == 0)
               chk(0, "R7", "ack with nothing pending", 1, 0);
            else begin
               item_t it;
               it = sb.pop_front();
               if (it.rd)
                  chk(rdata == it.d, "R4", "read data", rdata, it.d);
               else
                  chk(mem.exists(it.a) && mem[it.a] == it.d, "R5", "memory content after write",
                      mem.exists(it.a) ? mem[it.a] : 8'hxx, it.d);
            end
         end
      end
      sel_q = sel; we_q = mem_we_n; oe_q = mem_dq_oe; ack_q = ack; addr_q = mem_addr;
   end

   // driver
   task automatic issue(input bit rd, input logic [17:0] a, input logic [7:0] d);
      item_t it;
      @(negedge clk);
      while (!ready) @(negedge clk);
      req_valid = 1; req_write = !rd; req_addr = a; req_wdata = d;
      it.rd = rd; it.a = a;
      it.d  = rd ? (shadow.exists(a) ? shadow[a] : 8'h00) : d;
      if (!rd) shadow[a] = d;
      sb.push_back(it);
      issued++;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic drain();
      @(negedge clk);
      while (sb.size() != 0 || !ready) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      chk(mem_ce1_n && !mem_ce2, "R1", "enables in reset", {mem_ce1_n, mem_ce2}, 2'b10);
      chk(mem_oe_n && mem_we_n, "R1", "oe/we in reset", {mem_oe_n, mem_we_n}, 2'b11);
      chk(!mem_dq_oe && !ack && ready, "R1", "bus/ack/ready in reset",
          {mem_dq_oe, ack, ready}, 3'b001);
      rst = 0;

      issue(0, 18'h00000, 8'hA5);
      issue(0, 18'h3FFFF, 8'h5A);
      issue(0, 18'h15555, 8'h0F);
      issue(0, 18'h2AAAA, 8'hF0);
      issue(1, 18'h00000, 8'h00);
      issue(1, 18'h3FFFF, 8'h00);
      issue(1, 18'h15555, 8'h00);
      issue(1, 18'h2AAAA, 8'h00);
      issue(1, 18'h12345, 8'h00);      // never written: R4 default
      issue(0, 18'h00000, 8'h3C);      // overwrite
      issue(1, 18'h00000, 8'h00);

      // R9: write request while busy must be ignored
      issue(1, 18'h15555, 8'h00);
      req_valid = 1; req_write = 1; req_addr = 18'h15555; req_wdata = 8'hFF;
      repeat (4) @(negedge clk);
      req_valid = 0;
      issue(1, 18'h15555, 8'h00);

      // R8: read immediately followed by a write
      issue(1, 18'h3FFFF, 8'h00);
      issue(0, 18'h00001, 8'h96);
      issue(1, 18'h00001, 8'h00);
      drain();
      repeat (GAP + 4) @(negedge clk);

      chk(pair_bad == 0, "R2", "enables not paired", pair_bad, 0);
      chk(sel_rises == issued, "R9", "memory cycles vs accepted requests", sel_rises, issued);
      chk(mem[18'h15555] == 8'h0F, "R9", "busy write left memory untouched",
          mem[18'h15555], 8'h0F);
      finish_run();
   end

endmodule